// File: doc/BRIEF.md
# Peripheral Interrupt Flag Register

This block gathers event indications from seven peripheral sources into one 8-bit flag register that the processor reads and writes. Five of the flags latch: a single-cycle event pulse sets them, and they stay set until software writes a zero to them. The other two report the state of the serial data buffers. They follow the buffer-full and buffer-empty levels, and they drop when the matching data register is read or written. Software cannot change either of them.

The capture/compare flag takes its event from one of two inputs, chosen by a mode select. In the pulse-width mode it takes no event at all. A flag sets whether or not its enable or the global enable is on. A registered interrupt request is raised when any flag is set while its own enable is set and the global enable is on.

Top module: `periph_irq_flags`

## Requirements
- R1: The flag layout is fixed. Bit 0 is timer overflow, bit 1 is timer period match, bit 2 is capture/compare, bit 3 is synchronous serial done, bit 4 is serial transmit, bit 5 is serial receive and bit 6 is conversion done.
- R2: Bit 7 of `rd_data` always reads 0, and software writes to bit 7 have no effect.
- R3: When `rst` is high at a clock edge, every flag and `irq` are 0 after that edge.
- R4: An event pulse on a latching source sets its flag at that clock edge, whatever the values of `ien` and `gie`.
- R5: A latching flag stays set until a write carries 0 in its bit. A write of 1 to a latching flag sets it.
- R6: The receive flag takes the value of `rx_full` at each edge. It is forced to 0 at an edge where `rx_data_rd` is high, and software writes to bit 5 are ignored.
- R7: The transmit flag takes the value of `tx_empty` at each edge. It is forced to 0 at an edge where `tx_data_wr` is high, and software writes to bit 4 are ignored.
- R8: The mode select `ccp_mode` decides what sets the capture/compare flag. With 2'b00 only `ccp_capture` sets it, with 2'b01 only `ccp_compare` sets it, and with 2'b10 or 2'b11 nothing sets it.
- R9: `irq` is a register. After each edge it holds `gie` AND the OR over all bits of (flags AND `ien`), using the flags as they stood before that edge.
- R10: When an event and a software write of 0 reach the same latching flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register value |
| adc_done | input | 1 | Conversion-complete pulse |
| ssp_done | input | 1 | Synchronous serial transfer-complete pulse |
| ccp_capture | input | 1 | Capture event pulse |
| ccp_compare | input | 1 | Compare match pulse |
| ccp_mode | input | 2 | 00 capture, 01 compare, 1x pulse-width |
| tmr_match | input | 1 | Timer-to-period match pulse |
| tmr_ovf | input | 1 | Timer overflow pulse |
| rx_full | input | 1 | Receive buffer full level |
| rx_data_rd | input | 1 | Receive data register read strobe |
| tx_empty | input | 1 | Transmit buffer empty level |
| tx_data_wr | input | 1 | Transmit data register write strobe |
| ien | input | 7 | Per-source enables, same bit layout as the flags |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench uses the default parameters: seven sources in an 8-bit register. That is the only shape the fixed flag layout allows, so every bit position, including the unimplemented top bit, can be reached. The vector table reaches an event colliding with a clear, all four capture/compare modes, the buffer strobes overriding their levels, and enables changing one cycle before the request is sampled.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int NSRC  = 7;
  localparam int REG_W = 8;

  localparam int BIT_TMR_OVF   = 0;
  localparam int BIT_TMR_MATCH = 1;
  localparam int BIT_CCP       = 2;
  localparam int BIT_SSP       = 3;
  localparam int BIT_TX        = 4;
  localparam int BIT_RX        = 5;
  localparam int BIT_ADC       = 6;

  localparam int NSTICKY = 5;

  typedef enum logic [1:0] {
    CCP_CAPTURE = 2'b00,
    CCP_COMPARE = 2'b01,
    CCP_PWM     = 2'b10,
    CCP_PWM_ALT = 2'b11
  } ccp_mode_e;
endpackage

// File: rtl/pirq_sticky_bank.sv
module pirq_sticky_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         wr_en,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        q[i] <= 1'b0;
      else if (evt[i])
        q[i] <= 1'b1;
      else if (wr_en)
        q[i] <= wr_bits[i];
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> q[i]);  // R4 R10
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (q[i] && !wr_en) |=> q[i]);  // R5
  end
endmodule

// File: rtl/pirq_status_flag.sv
module pirq_status_flag (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic clr_strobe,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= 1'b0;
    else
      q <= level & ~clr_strobe;
  end

  AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clr_strobe |=> !q);  // R6 R7
  AST_FOLLOWS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!clr_strobe && level) |=> q);  // R6 R7
endmodule

// File: rtl/pirq_req_gen.sv
module pirq_req_gen #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] ien,
  input  logic         gie,
  output logic         irq
);
  logic any_pending;
  assign any_pending = |(flags & ien);

  always_ff @(posedge clk) begin
    if (rst)
      irq <= 1'b0;
    else
      irq <= gie & any_pending;
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq);  // R9
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (rst)
    (gie && (flags & ien) != '0) |=> irq);  // R9
endmodule

// File: rtl/periph_irq_flags.sv
module periph_irq_flags
  import pirq_pkg::*;
#(
  parameter int SRC_N = NSRC,
  parameter int W     = REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     rd_data,
  input  logic             adc_done,
  input  logic             ssp_done,
  input  logic             ccp_capture,
  input  logic             ccp_compare,
  input  logic [1:0]       ccp_mode,
  input  logic             tmr_match,
  input  logic             tmr_ovf,
  input  logic             rx_full,
  input  logic             rx_data_rd,
  input  logic             tx_empty,
  input  logic             tx_data_wr,
  input  logic [SRC_N-1:0] ien,
  input  logic             gie,
  output logic             irq
);
  localparam int PAD_W = W - SRC_N;
  localparam int STICKY_POS [NSTICKY] =
    '{BIT_TMR_OVF, BIT_TMR_MATCH, BIT_CCP, BIT_SSP, BIT_ADC};

  logic               ccp_evt;
  logic [NSTICKY-1:0] sticky_evt;
  logic [NSTICKY-1:0] sticky_wr;
  logic [NSTICKY-1:0] sticky_q;
  logic               rx_q;
  logic               tx_q;
  logic [SRC_N-1:0]   flags;
  logic               unused_wr_bits;

  // The capture/compare source depends on the mode select
  always_comb begin
    unique case (ccp_mode_e'(ccp_mode))
      CCP_CAPTURE: ccp_evt = ccp_capture;
      CCP_COMPARE: ccp_evt = ccp_compare;
      default:     ccp_evt = 1'b0;
    endcase
  end

  always_comb begin
    sticky_evt = {adc_done, ssp_done, ccp_evt, tmr_match, tmr_ovf};
    for (int k = 0; k < NSTICKY; k++)
      sticky_wr[k] = wr_data[STICKY_POS[k]];
  end

  // Bit 7 and the two serial bits of a write go nowhere
  assign unused_wr_bits = ^{wr_data[W-1:SRC_N], wr_data[BIT_RX], wr_data[BIT_TX]};

  pirq_sticky_bank #(.N(NSTICKY)) u_sticky (
    .clk     (clk),
    .rst     (rst),
    .evt     (sticky_evt),
    .wr_en   (wr_en),
    .wr_bits (sticky_wr),
    .q       (sticky_q)
  );

  pirq_status_flag u_rx (
    .clk        (clk),
    .rst        (rst),
    .level      (rx_full),
    .clr_strobe (rx_data_rd),
    .q          (rx_q)
  );

  pirq_status_flag u_tx (
    .clk        (clk),
    .rst        (rst),
    .level      (tx_empty),
    .clr_strobe (tx_data_wr),
    .q          (tx_q)
  );

  always_comb begin
    flags = '0;
    for (int k = 0; k < NSTICKY; k++)
      flags[STICKY_POS[k]] = sticky_q[k];
    flags[BIT_RX] = rx_q;
    flags[BIT_TX] = tx_q;
  end

  assign rd_data = {{PAD_W{1'b0}}, flags};

  pirq_req_gen #(.N(SRC_N)) u_req (
    .clk   (clk),
    .rst   (rst),
    .flags (flags),
    .ien   (ien),
    .gie   (gie),
    .irq   (irq)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !irq));  // R3
  AST_PWM_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (ccp_mode[1] && !wr_en && !rd_data[BIT_CCP]) |=> !rd_data[BIT_CCP]);  // R8
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[W-1]) |=> !rd_data[W-1]);  // R2
endmodule

// File: tb/periph_irq_flags_bench.sv
module periph_irq_flags_bench;
  typedef struct packed {
    logic       wr;
    logic [7:0] wd;
    logic [5:0] ev;   // [5]adc [4]ssp [3]capture [2]compare [1]match [0]ovf
    logic [1:0] md;
    logic       rxf;
    logic       rxr;
    logic       txe;
    logic       txw;
    logic [6:0] ie;
    logic       g;
    logic [7:0] erd;
    logic       eirq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 6'b100000, 2'b00, 1'b0,1'b0,1'b0,1'b0, 7'h00, 1'b0, 8'h40, 1'b0}, // 0 R4
    '{1'b0, 8'h00, 6'b000000, 2'b00, 1'b0,1'b0,1'b0,1'b0, 7'h40, 1'b0, 8'h40, 1'b0}, // 1 R4
    '{1'b0, 8'h00, 6'b000000, 2'b00, 1'b0,1'b0,1'b0,1'b0, 7'h40, 1'b1, 8'h40, 1'b1}, // 2 R9
    '{1'b1, 8'h00, 6'b000000, 2'b00, 1'b0,1'b0,1'b0,1'b0, 7'h40, 1'b1, 8'h00, 1'b1}, // 3 R5
    '{1'b0, 8'h00, 6'b000000, 2'b00, 1'b0,1'b0,1'b0,1'b0, 7'h40, 1'b1, 8'h00, 1'b0}, // 4 R5
    '{1'b1, 8'h00, 6'b000001, 2'b00, 1'b0,1'b0,1'b0,1'b0, 7'h40, 1'b1, 8'h01, 1'b0}, // 5 R10
    '{1'b0, 8'h00, 6'b001100, 2'b10, 1'b0,1'b0,1'b0,1'b0, 7'h40, 1'b1, 8'h01, 1'b0}, // 6 R8
    '{1'b0, 8'h00, 6'b000100, 2'b00, 1'b0,1'b0,1'b0,1'b0, 7'h40, 1'b1, 8'h01, 1'b0}, // 7 R8
    '{1'b0, 8'h00, 6'b001000, 2'b00, 1'b0,1'b0,1'b0,1'b0, 7'h40, 1'b1, 8'h05, 1'b0}, // 8 R8
    '{1'b1, 8'h00, 6'b000100, 2'b01, 1'b0,1'b0,1'b0,1'b0, 7'h40, 1'b1, 8'h04, 1'b0}, // 9 R8
    '{1'b0, 8'h00, 6'b001100, 2'b11, 1'b1,1'b0,1'b1,1'b0, 7'h40, 1'b1, 8'h34, 1'b0}, // 10 R6 R7
    '{1'b1, 8'h00, 6'b000000, 2'b00, 1'b1,1'b0,1'b1,1'b0, 7'h40, 1'b1, 8'h30, 1'b0}, // 11 R6
    '{1'b0, 8'h00, 6'b000000, 2'b00, 1'b1,1'b1,1'b1,1'b0, 7'h40, 1'b1, 8'h10, 1'b0}, // 12 R6
    '{1'b0, 8'h00, 6'b000000, 2'b00, 1'b0,1'b0,1'b1,1'b1, 7'h40, 1'b1, 8'h00, 1'b0}, // 13 R7
    '{1'b0, 8'h00, 6'b000000, 2'b00, 1'b0,1'b0,1'b1,1'b0, 7'h10, 1'b1, 8'h10, 1'b0}, // 14 R9
    '{1'b0, 8'h00, 6'b000000, 2'b00, 1'b0,1'b0,1'b1,1'b0, 7'h10, 1'b1, 8'h10, 1'b1}, // 15 R9
    '{1'b1, 8'hFF, 6'b000000, 2'b00, 1'b0,1'b0,1'b1,1'b0, 7'h10, 1'b1, 8'h5F, 1'b1}, // 16 R2 R5
    '{1'b1, 8'h80, 6'b000000, 2'b00, 1'b0,1'b0,1'b0,1'b0, 7'h10, 1'b1, 8'h00, 1'b1}, // 17 R2
    '{1'b0, 8'h00, 6'b010010, 2'b00, 1'b0,1'b0,1'b0,1'b0, 7'h08, 1'b0, 8'h0A, 1'b0}, // 18 R1
    '{1'b0, 8'h00, 6'b000000, 2'b00, 1'b0,1'b0,1'b0,1'b0, 7'h08, 1'b1, 8'h0A, 1'b1}  // 19 R9
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       adc_done = 1'b0, ssp_done = 1'b0, ccp_capture = 1'b0, ccp_compare = 1'b0;
  logic [1:0] ccp_mode = 2'b00;
  logic       tmr_match = 1'b0, tmr_ovf = 1'b0;
  logic       rx_full = 1'b0, rx_data_rd = 1'b0, tx_empty = 1'b0, tx_data_wr = 1'b0;
  logic [6:0] ien = '0;
  logic       gie = 1'b0;
  logic       irq;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  periph_irq_flags u_periph_irq_flags (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .adc_done(adc_done), .ssp_done(ssp_done), .ccp_capture(ccp_capture),
    .ccp_compare(ccp_compare), .ccp_mode(ccp_mode), .tmr_match(tmr_match),
    .tmr_ovf(tmr_ovf), .rx_full(rx_full), .rx_data_rd(rx_data_rd),
    .tx_empty(tx_empty), .tx_data_wr(tx_data_wr), .ien(ien), .gie(gie), .irq(irq)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    wr_en = v.wr; wr_data = v.wd;
    adc_done = v.ev[5]; ssp_done = v.ev[4]; ccp_capture = v.ev[3];
    ccp_compare = v.ev[2]; tmr_match = v.ev[1]; tmr_ovf = v.ev[0];
    ccp_mode = v.md; rx_full = v.rxf; rx_data_rd = v.rxr;
    tx_empty = v.txe; tx_data_wr = v.txw; ien = v.ie; gie = v.g;
  endtask

  task automatic idle();
    drive('0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    // Reset state, R3
    repeat (2) @(negedge clk);
    check8("R3 reset rd_data", rd_data, 8'h00);
    check8("R3 reset irq", {7'd0, irq}, 8'h00);
    rst = 1'b0;

    // Vector table: drive at negedge, sample at the following negedge
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check8($sformatf("vector %0d rd_data R1 R2 R4-R8 R10", i), rd_data, VEC[i].erd);
      check8($sformatf("vector %0d irq R9", i), {7'd0, irq}, {7'd0, VEC[i].eirq});
    end
    idle();

    // Reset with flags set clears everything, R3
    rst = 1'b1;
    @(negedge clk);
    check8("R3 mid-run rd_data", rd_data, 8'h00);
    check8("R3 mid-run irq", {7'd0, irq}, 8'h00);
    rst = 1'b0;

    // Each latching source lands on its own bit, R1
    for (int k = 0; k < 5; k++) begin
      vec_t v;
      logic [7:0] exp;
      v = '0;
      unique case (k)
        0: begin v.ev = 6'b000001; exp = 8'h01; end
        1: begin v.ev = 6'b000010; exp = 8'h02; end
        2: begin v.ev = 6'b001000; exp = 8'h04; end
        3: begin v.ev = 6'b010000; exp = 8'h08; end
        default: begin v.ev = 6'b100000; exp = 8'h40; end
      endcase
      drive(v);
      @(negedge clk);
      check8($sformatf("R1 source %0d bit position", k), rd_data, exp);
      idle();
      wr_en = 1'b1;
      @(negedge clk);
      check8($sformatf("R5 source %0d cleared by write", k), rd_data, 8'h00);
      idle();
    end

    // Write of 1 to a read-only serial bit does nothing, R6 R7
    wr_en = 1'b1; wr_data = 8'h30;
    @(negedge clk);
    check8("R6 R7 write to serial bits ignored", rd_data, 8'h00);
    idle();
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule